// File: doc/BRIEF.md
# Two-Thread Partitioned Pipeline Queue

This queue sits between two pipeline stages that are used by two hardware threads at once. Its storage is cut into two fixed halves of equal size, one owned by each thread. A thread whose consumer stops taking entries can fill only its own half, so it never takes slots from the other thread. Each half keeps its own entries in order. The two threads may drift apart freely, so one can keep moving while the other waits.

The producer presents one write per cycle, tagged with a thread number. Each thread has its own full flag, which the producer uses for back-pressure. The consumer side gives one ready line per thread. A single read port hands out the head entry of one thread per cycle. A two-way round-robin arbiter chooses among the threads that both have data and are ready. A write that arrives at a full half is dropped and reported on a per-thread error pulse.

Top module: `tpq_partitioned_queue`

## Requirements
- R1: Each thread holds at most DEPTH/2 entries (2 with the default DEPTH of 4). `full[t]` is high exactly when thread t holds DEPTH/2 entries.
- R2: A write with `wr_tid` = t is discarded when `full[t]` is high and thread t is not read in the same cycle. `ovf_err[t]` is then high for exactly the next cycle, and the thread's contents do not change.
- R3: While one thread is full and its `rd_ready` is low, the other thread still accepts writes and still delivers reads.
- R4: Entries of one thread leave the read port in the order they were written, with their payload unchanged.
- R5: `rd_valid` is high in a cycle exactly when some thread t holds an entry and `rd_ready[t]` is high. `rd_tid` (0 = thread 0, 1 = thread 1) names the thread being read, and that entry is removed at the clock edge ending the cycle.
- R6: When both threads are eligible, the thread not granted most recently wins. The first such choice after reset goes to thread 0.
- R7: When only one thread is eligible, that thread is read in every such cycle.
- R8: A write and a read of the same full thread in one cycle are both carried out. The write is accepted, the entry count stays at DEPTH/2, and no error is raised.
- R9: After reset both halves are empty, and `full`, `ovf_err` and `rd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write request this cycle |
| wr_tid | input | 1 | Thread that owns the write |
| wr_data | input | DATA_W | Write payload |
| rd_ready | input | 2 | Per-thread downstream ready |
| full | output | 2 | Per-thread half full |
| ovf_err | output | 2 | Per-thread pulse after a dropped write |
| rd_valid | output | 1 | Read port carries an entry |
| rd_tid | output | 1 | Thread of the entry on the read port |
| rd_data | output | DATA_W | Payload of the entry on the read port |

## Verification
The bench fills a thread whose consumer is stalled and then pushes one extra write to it. A design that lets a thread spill into the other half would accept that write, and would later block the running thread. The bench writes and reads the same full thread in one cycle. A design that checks the full flag without looking at the read would drop the write and raise a false error. It also holds both threads eligible for several cycles in a row, next to stretches where only one is eligible. An arbiter that toggles without regard to eligibility, or that keeps favouring one thread, shows up as a wrong `rd_tid`. A long pseudo-random run at the end compares every payload against per-thread expected queues, which catches any reordering or slot corruption.

// File: rtl/tpq_pkg.sv
package tpq_pkg;

    // Number of hardware threads sharing the queue; the structure is built for two.
    localparam int unsigned TPQ_THREADS = 2;

    typedef logic [TPQ_THREADS-1:0] thr_vec_t;

    // Round-robin choice between two requesters.
    // last_won names the thread granted most recently (1 = thread 1).
    function automatic thr_vec_t tpq_rr_pick(input thr_vec_t req, input logic last_won);
        thr_vec_t g;
        g = '0;
        case (req)
            2'b01:   g = 2'b01;
            2'b10:   g = 2'b10;
            2'b11:   g = last_won ? 2'b01 : 2'b10;
            default: g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/tpq_lane.sv
// One thread's private half: a ring buffer with its own head, tail and count.
module tpq_lane #(
    parameter int unsigned SLOTS  = 2,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              nonempty,
    output logic              is_full,
    output logic              ovf
);

    localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int unsigned CNT_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0] mem;
        logic [IDX_W-1:0]             head;
        logic [IDX_W-1:0]             tail;
        logic [CNT_W-1:0]             cnt;
        logic                         ovf;
    } lane_st_t;

    lane_st_t s_q, s_d;
    logic     take;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] idx);
        return (idx == IDX_W'(SLOTS - 1)) ? '0 : idx + 1'b1;
    endfunction

    assign is_full   = (s_q.cnt == CNT_W'(SLOTS));
    assign nonempty  = (s_q.cnt != '0);
    assign head_data = s_q.mem[s_q.head];
    assign ovf       = s_q.ovf;

    // A full half still takes a write when its head leaves in the same cycle.
    assign take = push && (!is_full || pop);

    always_comb begin
        s_d = s_q;
        if (pop) begin
            s_d.head = bump(s_q.head);
        end
        if (take) begin
            s_d.mem[s_q.tail] = push_data;
            s_d.tail          = bump(s_q.tail);
        end
        case ({take, pop})
            2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
        s_d.ovf = push && !take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(SLOTS)); // R1

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full && !pop) |=> (ovf && $stable(s_q.cnt))); // R2

    AST_SWAP_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && is_full) |=> (is_full && !ovf)); // R8

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> nonempty); // R5

endmodule

// File: rtl/tpq_arb.sv
// Two-way round-robin read arbiter.
module tpq_arb
    import tpq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  thr_vec_t elig,
    output thr_vec_t grant
);

    typedef struct packed {
        logic last_won;
    } arb_st_t;

    arb_st_t s_q, s_d;

    always_comb begin
        s_d   = s_q;
        grant = tpq_rr_pick(elig, s_q.last_won);
        if (grant != '0) begin
            s_d.last_won = grant[1];
        end
    end

    // Reset state says thread 1 won last, so thread 0 takes the first tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{last_won: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R5

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~elig) == '0); // R5

    AST_TIE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == 2'b11) |=> (elig != 2'b11 || grant != $past(grant))); // R6

    AST_SOLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(elig) |-> (grant == elig)); // R7

endmodule

// File: rtl/tpq_partitioned_queue.sv
module tpq_partitioned_queue
    import tpq_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_tid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_ready,
    output logic [1:0]        full,
    output logic [1:0]        ovf_err,
    output logic              rd_valid,
    output logic              rd_tid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned HALF = DEPTH / 2;

    thr_vec_t          push_v;
    thr_vec_t          nonempty_v;
    thr_vec_t          elig_v;
    thr_vec_t          grant_v;
    logic [DATA_W-1:0] head_data [TPQ_THREADS];

    for (genvar t = 0; t < TPQ_THREADS; t++) begin : g_lane
        assign push_v[t] = wr_valid && (wr_tid == 1'(t));

        tpq_lane #(
            .SLOTS  (HALF),
            .DATA_W (DATA_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_v[t]),
            .push_data (wr_data),
            .pop       (grant_v[t]),
            .head_data (head_data[t]),
            .nonempty  (nonempty_v[t]),
            .is_full   (full[t]),
            .ovf       (ovf_err[t])
        );
    end

    assign elig_v = nonempty_v & rd_ready;

    tpq_arb u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig_v),
        .grant (grant_v)
    );

    assign rd_valid = |grant_v;
    assign rd_tid   = grant_v[1];

    always_comb begin
        rd_data = '0;
        for (int t = 0; t < TPQ_THREADS; t++) begin
            if (grant_v[t]) begin
                rd_data = head_data[t];
            end
        end
    end

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == |(nonempty_v & rd_ready)); // R5

    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err != '0) |-> ($past(wr_valid) && $past(full[wr_tid]) == 1'b1)); // R2

endmodule

// File: tb/sim_tpq_partitioned_queue.sv
`timescale 1ns/1ps
module sim_tpq_partitioned_queue;

    localparam int DEPTH  = 4;
    localparam int HALF   = DEPTH / 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_valid;
    logic              wr_tid;
    logic [DATA_W-1:0] wr_data;
    logic [1:0]        rd_ready;
    logic [1:0]        full;
    logic [1:0]        ovf_err;
    logic              rd_valid;
    logic              rd_tid;
    logic [DATA_W-1:0] rd_data;

    always #5 clk = ~clk;

    tpq_partitioned_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_tid(wr_tid),
        .wr_data(wr_data), .rd_ready(rd_ready), .full(full), .ovf_err(ovf_err),
        .rd_valid(rd_valid), .rd_tid(rd_tid), .rd_data(rd_data)
    );

    int checks = 0;
    int bad    = 0;
    bit done   = 0;

    logic [DATA_W-1:0] sb0[$];
    logic [DATA_W-1:0] sb1[$];
    logic              last_m  = 1'b1;
    logic [1:0]        ovf_exp = 2'b00;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops the expected queue of the thread being read and compares payloads.
    always @(negedge clk) begin
        #2;
        if (rst_n && rd_valid) begin
            if (rd_tid == 1'b0) begin
                if (sb0.size() == 0) chk(0, "R4", "read from empty thread0", 0, 1);
                else chk(rd_data == sb0[0], "R4", "thread0 data", rd_data, sb0[0]);
                if (sb0.size() != 0) void'(sb0.pop_front());
            end else begin
                if (sb1.size() == 0) chk(0, "R4", "read from empty thread1", 0, 1);
                else chk(rd_data == sb1[0], "R4", "thread1 data", rd_data, sb1[0]);
                if (sb1.size() != 0) void'(sb1.pop_front());
            end
        end
    end

    // Driver: one cycle of stimulus plus control-path checks against the model.
    task automatic cycle(input bit wv, input bit wt, input logic [DATA_W-1:0] wd,
                         input logic [1:0] rdy);
        int s0, s1, sz, popt;
        logic [1:0] elig;
        logic gv, gt;
        bit accept;
        @(negedge clk);
        wr_valid = wv; wr_tid = wt; wr_data = wd; rd_ready = rdy;
        #1;
        s0   = sb0.size();
        s1   = sb1.size();
        elig = {(s1 > 0) && rdy[1], (s0 > 0) && rdy[0]};
        gv   = (elig != 2'b00);
        gt   = (elig == 2'b11) ? ~last_m : elig[1];
        chk(rd_valid == gv, "R5", "rd_valid", rd_valid, gv);
        if (gv) begin
            if (elig == 2'b11) chk(rd_tid == gt, "R6", "tie winner", rd_tid, gt);
            else               chk(rd_tid == gt, "R7", "sole winner", rd_tid, gt);
            last_m = gt;
        end
        chk(full[0] == (s0 == HALF), "R1", "full[0]", full[0], s0 == HALF);
        chk(full[1] == (s1 == HALF), "R1", "full[1]", full[1], s1 == HALF);
        chk(ovf_err == ovf_exp, "R2", "ovf_err", ovf_err, ovf_exp);
        sz      = wt ? s1 : s0;
        popt    = (gv && gt == wt) ? 1 : 0;
        accept  = wv && ((sz - popt) < HALF);
        ovf_exp = 2'b00;
        if (wv && !accept) ovf_exp[wt] = 1'b1;
        #2;
        if (accept) begin
            if (wt) sb1.push_back(wd);
            else    sb0.push_back(wd);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        rst_n = 1'b0; wr_valid = 0; wr_tid = 0; wr_data = '0; rd_ready = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R9: reset state
        chk(full == 2'b00, "R9", "full after reset", full, 0);
        chk(ovf_err == 2'b00, "R9", "ovf after reset", ovf_err, 0);
        chk(rd_valid == 1'b0, "R9", "rd_valid after reset", rd_valid, 0);

        // R1/R2: thread 0 stalled, filled past its half
        cycle(1, 0, 8'h10, 2'b10);
        cycle(1, 0, 8'h11, 2'b10);
        cycle(1, 0, 8'h12, 2'b10);   // dropped
        cycle(0, 0, 8'h00, 2'b10);   // ovf_err[0] seen here
        chk(full[0] == 1'b1, "R1", "thread0 full at half", full[0], 1);

        // R3: thread 1 keeps flowing while thread 0 is stuck full
        for (int i = 0; i < 8; i++) cycle(1, 1, 8'h40 + 8'(i), 2'b10);
        cycle(1, 0, 8'h13, 2'b10);   // dropped again
        cycle(0, 0, 8'h00, 2'b10);
        chk(sb1.size() == 0 && full[1] == 1'b0, "R3", "thread1 drained", full[1], 0);

        // R8: write and read on the full thread in the same cycle
        cycle(1, 0, 8'h14, 2'b01);
        cycle(0, 0, 8'h00, 2'b00);
        chk(full[0] == 1'b1, "R8", "thread0 stays full after swap", full[0], 1);
        chk(ovf_err[0] == 1'b0, "R8", "no error on swap", ovf_err[0], 0);

        // R4: drain thread 0 in order
        for (int i = 0; i < 3; i++) cycle(0, 0, 8'h00, 2'b01);

        // R6: both threads loaded, then both ready
        cycle(1, 0, 8'h20, 2'b00);
        cycle(1, 1, 8'h30, 2'b00);
        cycle(1, 0, 8'h21, 2'b00);
        cycle(1, 1, 8'h31, 2'b00);
        for (int i = 0; i < 5; i++) cycle(0, 0, 8'h00, 2'b11);

        // Mixed traffic from an LFSR
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cycle(lfsr[0], lfsr[3], lfsr[15:8], lfsr[6:5]);
        end
        for (int i = 0; i < 6; i++) cycle(0, 0, 8'h00, 2'b11);
        chk(sb0.size() == 0 && sb1.size() == 0, "R4", "all entries delivered",
            sb0.size() + sb1.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule